// File: doc/BRIEF.md
# Multi-Cycle Processor Datapath

This block is the 32-bit datapath of a processor that spends several clock cycles on each instruction. It handles a small load/store instruction set: register-to-register add, subtract, and, or and signed set-less-than, plus word load, word store, branch-on-equal and absolute jump. One memory port carries both instruction fetches and data accesses. A single ALU does every calculation, including the program counter increment and the branch target. Every intermediate result is latched into a holding register so that the ALU is free again on the next cycle. The holding registers are the instruction register, the memory data register, the two operand registers and the ALU result register.

An external sequencer drives all select and enable inputs on every cycle. It decides what to do next from the opcode, funct and zero outputs. The memory array sits outside the block: the block supplies address, write data and strobes, and it receives read data back. The register file and all steering multiplexers are inside the block.

Top module: `mc_datapath`

## Requirements
- R1: A synchronous active-high reset clears the program counter, instruction register, memory data register, both operand registers and the ALU result register to zero. Right after reset, opcode and funct read 0, and mem_addr reads 0 whether addr_sel is 0 or 1.
- R2: mem_addr shows the program counter when addr_sel is 0 and the ALU result register when addr_sel is 1. mem_wdata always shows operand register B. mem_re and mem_we follow mem_rd and mem_wr.
- R3: The instruction register loads mem_rdata on the rising edge where ir_we is high and holds its value otherwise. opcode is instruction bits 31:26 and funct is bits 5:0. The memory data register, A, B and the ALU result register load on every edge.
- R4: On every edge, A captures the register addressed by instruction bits 25:21 and B captures the register addressed by bits 20:16.
- R5: alu_op selects the ALU function: 000 is and, 001 is or, 010 is add, 110 is subtract, and 111 is a signed compare that returns 1 when the first input is less than the second and 0 otherwise. zero is high exactly when the ALU result is 0.
- R6: The first ALU input is the program counter when srca_sel is 0 and A when it is 1. srcb_sel picks the second input: 0 is B, 1 is the constant 4, 2 is the sign-extended bits 15:0, and 3 is that sign-extended value shifted left by two.
- R7: When rf_we is high, the register file writes on the next edge. The destination is instruction bits 20:16 when dst_sel is 0 and bits 15:11 when it is 1. The write data is the ALU result register when wb_sel is 0 and the memory data register when it is 1.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: The program counter loads on an edge where pc_we is high, or where pc_we_cond and zero are both high. pc_src selects the new value: 0 is the live ALU result, 1 is the ALU result register, 2 is {PC[31:28], instruction bits 25:0, 00}, and 3 behaves like 0.
- R10: A branch whose compare finds equal operands moves the program counter to the incremented PC plus the sign-extended offset shifted left by two. This holds for backward offsets as well. When the operands differ, the program counter stays at the incremented PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_we | input | 1 | Unconditional program counter write |
| pc_we_cond | input | 1 | Program counter write when zero is high |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 ALU result register |
| mem_rd | input | 1 | Memory read request from the sequencer |
| mem_wr | input | 1 | Memory write request from the sequencer |
| ir_we | input | 1 | Instruction register load enable |
| rf_we | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination field: 0 bits 20:16, 1 bits 15:11 |
| wb_sel | input | 1 | Write-back source: 0 ALU result register, 1 memory data register |
| srca_sel | input | 1 | ALU first input: 0 PC, 1 A |
| srcb_sel | input | 2 | ALU second input: B, 4, immediate, immediate shifted by 2 |
| alu_op | input | 3 | ALU function code |
| pc_src | input | 2 | Program counter source select |
| mem_addr | output | 32 | Shared memory address |
| mem_wdata | output | 32 | Memory write data (operand B) |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 32 | Memory read data |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU result equals zero |

## Verification
The assertions assume the sequencer is well behaved. It raises ir_we only in fetch cycles, it uses pc_we_cond only together with a subtract and pc_src 1, and it lets a fresh instruction settle for one decode cycle before A and B are used. The bench acts as that sequencer and issues only complete step sequences for fetch, decode, execute, memory and write-back, so the assumptions always hold. The sweep loads every pair from a set of boundary operands, including sign-bit and all-ones values, and runs each of the five ALU functions on every pair. It then stores each result and checks it against an arithmetic model. Further sequences cover register 0, a negative store offset, and branches that are taken forward, taken backward and not taken; each of these is followed by a fetch-address check.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCB_REG  = 2'd0,
    SRCB_FOUR = 2'd1,
    SRCB_IMM  = 2'd2,
    SRCB_IMM4 = 2'd3
  } srcb_e;

  typedef enum logic [1:0] {
    PCSRC_ALU  = 2'd0,
    PCSRC_HELD = 2'd1,
    PCSRC_JUMP = 2'd2,
    PCSRC_RSVD = 2'd3
  } pcsrc_e;

  // instruction field positions, fixed by the encoding
  localparam int OPC_LSB  = 26;
  localparam int RS_LSB   = 21;
  localparam int RT_LSB   = 16;
  localparam int RD_LSB   = 11;
  localparam int IMM_W    = 16;
  localparam int JFIELD_W = 26;
  localparam int FIELD6_W = 6;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            zero
);

  logic signed_lt;

  assign signed_lt = ($signed(a) < $signed(b));

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, signed_lt};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [XLEN-1:0]          wdata,
  input  logic [$clog2(DEPTH)-1:0] ra,
  input  logic [$clog2(DEPTH)-1:0] rb,
  output logic [XLEN-1:0]          rda,
  output logic [XLEN-1:0]          rdb
);

  localparam int AW = $clog2(DEPTH);

  logic [XLEN-1:0] regs [DEPTH];

  // entry 0 is never written; reads of index 0 are forced to zero
  always_ff @(posedge clk) begin
    if (we && (waddr != AW'(0))) regs[waddr] <= wdata;
  end

  assign rda = (ra == AW'(0)) ? '0 : regs[ra];
  assign rdb = (rb == AW'(0)) ? '0 : regs[rb];

endmodule

// File: rtl/mc_pc_unit.sv
module mc_pc_unit
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pc_we,
  input  logic                pc_we_cond,
  input  logic                zero,
  input  pcsrc_e              pc_src,
  input  logic [XLEN-1:0]     alu_y,
  input  logic [XLEN-1:0]     alu_held,
  input  logic [JFIELD_W-1:0] jfield,
  output logic [XLEN-1:0]     pc_q
);

  localparam int UPPER_W = XLEN - JFIELD_W - 2;

  logic [XLEN-1:0] jump_tgt;
  logic [XLEN-1:0] pc_next;
  logic            pc_load;

  assign jump_tgt = {pc_q[XLEN-1 -: UPPER_W], jfield, 2'b00};
  assign pc_load  = pc_we | (pc_we_cond & zero);

  always_comb begin
    case (pc_src)
      PCSRC_HELD: pc_next = alu_held;
      PCSRC_JUMP: pc_next = jump_tgt;
      default:    pc_next = alu_y;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          pc_q <= '0;
    else if (pc_load) pc_q <= pc_next;
  end

  // R9
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(pc_we || (pc_we_cond && zero)) |=> $stable(pc_q))
    else $error("pc changed without a write enable");

  // R9
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_we && pc_src == PCSRC_JUMP) |=>
      (pc_q[1:0] == 2'b00 &&
       pc_q[XLEN-1 -: UPPER_W] == $past(pc_q[XLEN-1 -: UPPER_W]) &&
       pc_q[JFIELD_W+1:2] == $past(jfield)))
    else $error("jump target malformed");

  // R10
  br_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_we_cond && zero && pc_src == PCSRC_HELD) |=> pc_q == $past(alu_held))
    else $error("taken branch did not load held target");

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_we,
  input  logic            pc_we_cond,
  input  logic            addr_sel,
  input  logic            mem_rd,
  input  logic            mem_wr,
  input  logic            ir_we,
  input  logic            rf_we,
  input  logic            dst_sel,
  input  logic            wb_sel,
  input  logic            srca_sel,
  input  logic [1:0]      srcb_sel,
  input  logic [2:0]      alu_op,
  input  logic [1:0]      pc_src,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            mem_re,
  output logic            mem_we,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            zero
);

  localparam int RIDX = $clog2(NREGS);

  // holding registers
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;

  logic [RIDX-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
  logic [XLEN-1:0] rf_rda, rf_rdb, rf_wd;
  logic [XLEN-1:0] imm_sx, imm_sh;
  logic [XLEN-1:0] srca, srcb, alu_y;
  logic            alu_zero;

  assign rs_idx = ir_q[RS_LSB +: RIDX];
  assign rt_idx = ir_q[RT_LSB +: RIDX];
  assign rd_idx = ir_q[RD_LSB +: RIDX];

  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sh = {imm_sx[XLEN-3:0], 2'b00};

  // write-back steering
  assign wr_idx = dst_sel ? rd_idx : rt_idx;
  assign rf_wd  = wb_sel ? mdr_q : aluout_q;

  mc_regfile #(.XLEN(XLEN), .DEPTH(NREGS)) u_rf (
    .clk  (clk),
    .we   (rf_we),
    .waddr(wr_idx),
    .wdata(rf_wd),
    .ra   (rs_idx),
    .rb   (rt_idx),
    .rda  (rf_rda),
    .rdb  (rf_rdb)
  );

  // ALU operand steering
  assign srca = srca_sel ? a_q : pc_q;

  always_comb begin
    case (srcb_e'(srcb_sel))
      SRCB_REG:  srcb = b_q;
      SRCB_FOUR: srcb = XLEN'(4);
      SRCB_IMM:  srcb = imm_sx;
      default:   srcb = imm_sh;
    endcase
  end

  mc_alu #(.XLEN(XLEN)) u_alu (
    .op  (alu_op_e'(alu_op)),
    .a   (srca),
    .b   (srcb),
    .y   (alu_y),
    .zero(alu_zero)
  );

  mc_pc_unit #(.XLEN(XLEN)) u_pc (
    .clk       (clk),
    .rst       (rst),
    .pc_we     (pc_we),
    .pc_we_cond(pc_we_cond),
    .zero      (alu_zero),
    .pc_src    (pcsrc_e'(pc_src)),
    .alu_y     (alu_y),
    .alu_held  (aluout_q),
    .jfield    (ir_q[JFIELD_W-1:0]),
    .pc_q      (pc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (ir_we) ir_q <= mem_rdata;
      mdr_q    <= mem_rdata;
      a_q      <= rf_rda;
      b_q      <= rf_rdb;
      aluout_q <= alu_y;
    end
  end

  // shared memory port
  assign mem_addr  = addr_sel ? aluout_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_re    = mem_rd;
  assign mem_we    = mem_wr;

  assign opcode = ir_q[OPC_LSB +: FIELD6_W];
  assign funct  = ir_q[FIELD6_W-1:0];
  assign zero   = alu_zero;

  // R8
  r0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == RIDX'(0)) |=> a_q == '0)
    else $error("register 0 read non-zero");

  // R7
  rf_wr_rd_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rf_we) && $past(wr_idx) != RIDX'(0) && rs_idx == $past(wr_idx))
      |-> rf_rda == $past(rf_wd))
    else $error("register write not visible on read");

  // R3
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ir_we |=> $stable(ir_q))
    else $error("instruction register changed without load");

endmodule

// File: tb/mc_datapath_bench.sv
module mc_datapath_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_WORDS  = 1024;

  logic        clk = 1'b0;
  logic        rst;
  logic        pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, ir_we;
  logic        rf_we, dst_sel, wb_sel, srca_sel;
  logic [1:0]  srcb_sel, pc_src;
  logic [2:0]  alu_op;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we;
  logic [5:0]  opcode, funct;
  logic        zero;

  logic [31:0] mem [MEM_WORDS];
  logic [31:0] sh  [32];
  logic [31:0] exp_pc;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_datapath u_mc_datapath (
    .clk(clk), .rst(rst), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
    .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_we(ir_we),
    .rf_we(rf_we), .dst_sel(dst_sel), .wb_sel(wb_sel), .srca_sel(srca_sel),
    .srcb_sel(srcb_sel), .alu_op(alu_op), .pc_src(pc_src),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .opcode(opcode),
    .funct(funct), .zero(zero)
  );

  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    pc_we = 0; pc_we_cond = 0; addr_sel = 0; mem_rd = 0; mem_wr = 0;
    ir_we = 0; rf_we = 0; dst_sel = 0; wb_sel = 0; srca_sel = 0;
    srcb_sel = 2'd0; alu_op = 3'b010; pc_src = 2'd0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // op index -> alu code, funct code, model result
  function automatic logic [2:0] op_code(input int k);
    case (k)
      0: return 3'b000; 1: return 3'b001; 2: return 3'b010;
      3: return 3'b110; default: return 3'b111;
    endcase
  endfunction

  function automatic logic [5:0] op_funct(input int k);
    case (k)
      0: return 6'h24; 1: return 6'h25; 2: return 6'h20;
      3: return 6'h22; default: return 6'h2a;
    endcase
  endfunction

  function automatic logic [31:0] op_model(input int k, input logic [31:0] a, input logic [31:0] b);
    case (k)
      0: return a & b;
      1: return a | b;
      2: return a + b;
      3: return a - b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic fetch_decode(input logic [31:0] instr);
    mem[exp_pc[11:2]] = instr;
    idle();
    mem_rd = 1; ir_we = 1; srcb_sel = 2'd1; pc_we = 1;
    #1;
    chk("R2/R9/R10 fetch address", mem_addr, exp_pc);
    tick();
    exp_pc = exp_pc + 32'd4;
    chk("R3 opcode", {26'd0, opcode}, {26'd0, instr[31:26]});
    chk("R3 funct", {26'd0, funct}, {26'd0, instr[5:0]});
    idle();
    srcb_sel = 2'd3;
    tick();
  endtask

  task automatic do_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm);
    logic [31:0] ea;
    fetch_decode({6'h23, rs, rt, imm});
    idle(); srca_sel = 1; srcb_sel = 2'd2; tick();
    ea = sh[rs] + sext(imm);
    idle(); addr_sel = 1; mem_rd = 1;
    #1;
    chk("R2 load address", mem_addr, ea);
    tick();
    idle(); rf_we = 1; dst_sel = 0; wb_sel = 1; tick();
    if (rt != 0) sh[rt] = mem[ea[11:2]];
  endtask

  task automatic do_sw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                       input string req);
    logic [31:0] ea;
    fetch_decode({6'h2b, rs, rt, imm});
    idle(); srca_sel = 1; srcb_sel = 2'd2; tick();
    ea = sh[rs] + sext(imm);
    idle(); addr_sel = 1; mem_wr = 1;
    #1;
    chk({req, " store address"}, mem_addr, ea);
    chk({req, " store data"}, mem_wdata, sh[rt]);
    chk("R2 write strobe", {31'd0, mem_we}, 32'd1);
    tick();
  endtask

  task automatic do_rtype(input int k, input logic [4:0] rd, input logic [4:0] rs,
                          input logic [4:0] rt);
    fetch_decode({6'h00, rs, rt, rd, 5'd0, op_funct(k)});
    idle(); srca_sel = 1; srcb_sel = 2'd0; alu_op = op_code(k); tick();
    idle(); rf_we = 1; dst_sel = 1; wb_sel = 0; tick();
    if (rd != 0) sh[rd] = op_model(k, sh[rs], sh[rt]);
  endtask

  task automatic do_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    bit eq;
    fetch_decode({6'h04, rs, rt, imm});
    eq = (sh[rs] == sh[rt]);
    idle(); srca_sel = 1; srcb_sel = 2'd0; alu_op = 3'b110;
    pc_we_cond = 1; pc_src = 2'd1;
    #1;
    chk("R5 zero flag on compare", {31'd0, zero}, {31'd0, eq});
    tick();
    if (eq) exp_pc = exp_pc + {sext(imm)[29:0], 2'b00};
  endtask

  task automatic do_jmp(input logic [25:0] tgt);
    fetch_decode({6'h02, tgt});
    idle(); pc_we = 1; pc_src = 2'd2; tick();
    exp_pc = {exp_pc[31:28], tgt, 2'b00};
  endtask

  logic [31:0] vals [8];

  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
    vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h0000_0005;
    vals[6] = 32'h1234_5678; vals[7] = 32'hFFFF_0000;
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) sh[i] = 32'd0;
    exp_pc = 32'd0;

    idle();
    rst = 1;
    repeat (3) tick();
    rst = 0;
    #1;
    // R1 reset state
    chk("R1 pc after reset", mem_addr, 32'd0);
    chk("R1 opcode after reset", {26'd0, opcode}, 32'd0);
    chk("R1 funct after reset", {26'd0, funct}, 32'd0);
    chk("R1 operand B after reset", mem_wdata, 32'd0);
    addr_sel = 1;
    #1;
    chk("R1 alu result register after reset", mem_addr, 32'd0);
    idle();

    // R4 R5 R6 R7: every operand pair with every ALU function
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int k = 0; k < 5; k++) begin
          mem[256] = vals[i];
          mem[257] = vals[j];
          do_lw(5'd1, 5'd0, 16'h0400);
          do_lw(5'd2, 5'd0, 16'h0404);
          do_rtype(k, 5'd3, 5'd1, 5'd2);
          do_sw(5'd3, 5'd0, 16'h0408, "R5 alu result");
          do_jmp(26'd0);
        end
      end
    end

    // R8: register 0 ignores load and ALU writes
    mem[256] = 32'hDEAD_BEEF;
    do_lw(5'd0, 5'd0, 16'h0400);
    do_sw(5'd0, 5'd0, 16'h0408, "R8 r0 after load");
    do_rtype(2, 5'd0, 5'd1, 5'd2);
    do_sw(5'd0, 5'd0, 16'h040C, "R8 r0 after add");

    // R6: negative sign-extended store offset
    mem[256] = 32'h0000_0500;
    do_lw(5'd4, 5'd0, 16'h0400);
    do_sw(5'd3, 5'd4, 16'hFFFC, "R6 negative offset");

    // R9 jump, R10 branches forward, backward, not taken
    do_jmp(26'h40);
    mem[256] = 32'h0000_0077;
    do_lw(5'd5, 5'd0, 16'h0400);
    do_lw(5'd6, 5'd0, 16'h0400);
    do_beq(5'd5, 5'd6, 16'h0003);
    do_beq(5'd5, 5'd6, 16'hFFFE);
    do_beq(5'd1, 5'd5, 16'h0005);
    do_jmp(26'd0);
    idle();
    #1;
    chk("R9 fetch after jump", mem_addr, exp_pc);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule